// File: doc/BRIEF.md
# Performance Monitor Register File

This block is the register file of a performance monitor that implements no event counters of its own. A processor pipeline presents one register access per cycle: a group number, a selector inside that group, a read/write flag, a flag saying the access comes from user mode, and write data. The block answers in the same cycle with read data and a flag that marks the access as undefined, so the pipeline can raise an undefined-instruction trap. Writes that are accepted update the stored state on the next rising clock edge.

The stored state is the monitor control word, a counter-enable word, an overflow-status word, an event-type byte, a user-access enable bit and an interrupt-enable word. The control word comes out of reset with the top byte of a supplied processor identification value and zero everywhere else, which reports that no event counters exist. The enable words are reached through separate set and clear selectors, and only the cycle-counter bit (bit 31) can change in them. The cycle-count and event-count selectors exist but read as zero and ignore writes.

Three groups are decoded: 12 holds the control, enable, overflow, software-increment and counter-select selectors; 13 holds the cycle-count, event-type and event-count selectors; 14 holds the user-enable and interrupt-enable selectors. A strap input turns the whole register space on or off. User-mode access is allowed for groups 12 and 13 only while the user-enable bit is set; reading the user-enable bit is always allowed; everything else in user mode is undefined.

Top module: `perfmon_regs`

## Requirements
- R1: After reset the control word (group 12, selector 0) reads as `cpu_id & 32'hFF00_0000`, and the enable words, the overflow word, the event type and the user-enable bit all read as zero.
- R2: A write to group 12 selector 0 changes only control bits 0, 3, 4 and 5 (mask 0x39) to the written values; all other control bits keep their value.
- R3: Group 12 selector 1 ORs write-data bit 31 into the counter-enable word, selector 2 clears bit 31 where write-data bit 31 is 1; no other bit changes, and both selectors read the same word.
- R4: A write to group 12 selector 3 clears every overflow bit written as 1; the overflow word reads as zero from reset since nothing in the block sets it.
- R5: A write to group 13 selector 1 stores write-data bits 7:0 as the event type; reads return it zero-extended to 32 bits.
- R6: Group 12 selectors 4 and 5 and group 13 selectors 0 and 2 read as zero and a write to them changes no state.
- R7: A write to group 14 selector 0 stores write-data bit 0 as the user-enable bit; reads return it in bit 0 with all other bits zero.
- R8: Group 14 selector 1 ORs write-data bit 31 into the interrupt-enable word, selector 2 clears it where write-data bit 31 is 1; both read the same word.
- R9: While the feature strap `feat_en` is 0, every access is undefined.
- R10: An access is undefined when the group is not 12, 13 or 14, or the selector is above 5 in group 12 or above 2 in groups 13 and 14.
- R11: A user-mode access to group 12 selectors 0 to 5 or group 13 selectors 0 to 2 is undefined while the user-enable bit is 0 and behaves as a privileged access while it is 1.
- R12: In user mode a read of group 14 selector 0 is always allowed; a write of it, and any access to group 14 selectors 1 and 2, is undefined.
- R13: An undefined access changes no state, and in its cycle `rsp_undef` is 1 and `rsp_rdata` is zero.
- R14: `rsp_rdata` and `rsp_undef` are combinational from the request and the current state; an accepted write is visible from the next clock edge; with `req_valid` low both outputs are zero, and writes return zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_id | input | 32 | Processor identification value, top byte copied into the control word at reset |
| feat_en | input | 1 | Strap enabling the register space |
| req_valid | input | 1 | Single-cycle access strobe |
| req_grp | input | 4 | Primary register group number |
| req_sel | input | 3 | Selector within the group |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_user | input | 1 | 1 when the access is from user mode |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, zero unless an accepted read |
| rsp_undef | output | 1 | Access is undefined and was rejected |

## Verification
The main sweep walks every group number from 0 to 15 against every selector, both directions and both privilege levels, once with the strap off and once with it on, and repeats that with the user-enable bit starting at 0 and at 1; this separates the decode of defined selectors from undefined ones, and the gating by the strap from the gating by privilege. Write data comes from a multiplicative pattern so that each write carries different masked and unmasked bits, which tells a correct write mask apart from one that is too wide or too narrow, and set selectors apart from clear selectors. Because every read is compared against a bench-side register model, a rejected write that leaked into state shows up on the next read of that register. Directed steps add the reset values, a read-after-write of the event type on the following cycle and the idle-strobe outputs.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam logic [3:0] GRP_CTRL = 4'd12;
    localparam logic [3:0] GRP_CNT  = 4'd13;
    localparam logic [3:0] GRP_USR  = 4'd14;

    typedef enum logic [3:0] {
        RID_CTRL,
        RID_CEN_SET,
        RID_CEN_CLR,
        RID_OVF,
        RID_RAZ,
        RID_EVT,
        RID_USREN,
        RID_IEN_SET,
        RID_IEN_CLR,
        RID_BAD
    } reg_id_e;

endpackage

// File: rtl/perfmon_decode.sv
module perfmon_decode
    import perfmon_pkg::*;
(
    input  logic [3:0] grp,
    input  logic [2:0] sel,
    input  logic       wr,
    input  logic       user,
    input  logic       feat,
    input  logic       usr_en,
    output reg_id_e    rid,
    output logic       undef
);

    reg_id_e rid_raw;
    logic    user_ok;

    always_comb begin
        rid_raw = RID_BAD;
        unique case (grp)
            GRP_CTRL: begin
                unique case (sel)
                    3'd0:       rid_raw = RID_CTRL;
                    3'd1:       rid_raw = RID_CEN_SET;
                    3'd2:       rid_raw = RID_CEN_CLR;
                    3'd3:       rid_raw = RID_OVF;
                    3'd4, 3'd5: rid_raw = RID_RAZ;
                    default:    rid_raw = RID_BAD;
                endcase
            end
            GRP_CNT: begin
                unique case (sel)
                    3'd0, 3'd2: rid_raw = RID_RAZ;
                    3'd1:       rid_raw = RID_EVT;
                    default:    rid_raw = RID_BAD;
                endcase
            end
            GRP_USR: begin
                unique case (sel)
                    3'd0:    rid_raw = RID_USREN;
                    3'd1:    rid_raw = RID_IEN_SET;
                    3'd2:    rid_raw = RID_IEN_CLR;
                    default: rid_raw = RID_BAD;
                endcase
            end
            default: rid_raw = RID_BAD;
        endcase
        rid = feat ? rid_raw : RID_BAD;
    end

    // user-mode permission: counter groups follow the enable bit,
    // the enable bit itself is readable, everything else is refused
    always_comb begin
        if (grp == GRP_CTRL || grp == GRP_CNT) begin
            user_ok = usr_en;
        end else begin
            user_ok = (rid == RID_USREN) && !wr;
        end
        undef = (rid == RID_BAD) || (user && !user_ok);
    end

endmodule

// File: rtl/perfmon_state.sv
module perfmon_state
    import perfmon_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          ID_TOP_W   = 8,
    parameter int          EVT_W      = 8,
    parameter logic [31:0] CTRL_WMASK = 32'h0000_0039
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cpu_id,
    input  logic              we,
    input  reg_id_e           rid,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] cnten_q,
    output logic [DATA_W-1:0] ovf_q,
    output logic [EVT_W-1:0]  evt_q,
    output logic              usren_q,
    output logic [DATA_W-1:0] inten_q
);

    localparam int          CC_BIT  = DATA_W - 1;
    localparam logic [DATA_W-1:0] CC_MASK = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] ID_MASK = {{ID_TOP_W{1'b1}}, {(DATA_W-ID_TOP_W){1'b0}}};
    localparam logic [DATA_W-1:0] WMASK   = CTRL_WMASK[DATA_W-1:0];

    logic [DATA_W-1:0] cc_bit_d;

    assign cc_bit_d = wdata & CC_MASK;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= cpu_id & ID_MASK;
            cnten_q <= '0;
            ovf_q   <= '0;
            evt_q   <= '0;
            usren_q <= 1'b0;
            inten_q <= '0;
        end else if (we) begin
            unique case (rid)
                RID_CTRL:    ctrl_q  <= (ctrl_q & ~WMASK) | (wdata & WMASK);
                RID_CEN_SET: cnten_q <= cnten_q | cc_bit_d;
                RID_CEN_CLR: cnten_q <= cnten_q & ~cc_bit_d;
                RID_OVF:     ovf_q   <= ovf_q & ~wdata;
                RID_EVT:     evt_q   <= wdata[EVT_W-1:0];
                RID_USREN:   usren_q <= wdata[0];
                RID_IEN_SET: inten_q <= inten_q | cc_bit_d;
                RID_IEN_CLR: inten_q <= inten_q & ~cc_bit_d;
                default: ;
            endcase
        end
    end

    // cycle-counter bit position is the top data bit
    if (CC_BIT != DATA_W - 1) begin : g_bad_cc
        initial $display("cycle counter bit outside data word");
    end

endmodule

// File: rtl/perfmon_rdmux.sv
module perfmon_rdmux
    import perfmon_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EVT_W  = 8
) (
    input  reg_id_e           rid,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [DATA_W-1:0] cnten_q,
    input  logic [DATA_W-1:0] ovf_q,
    input  logic [EVT_W-1:0]  evt_q,
    input  logic              usren_q,
    input  logic [DATA_W-1:0] inten_q,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        unique case (rid)
            RID_CTRL:                 rdata = ctrl_q;
            RID_CEN_SET, RID_CEN_CLR: rdata = cnten_q;
            RID_OVF:                  rdata = ovf_q;
            RID_EVT:                  rdata = {{(DATA_W-EVT_W){1'b0}}, evt_q};
            RID_USREN:                rdata = {{(DATA_W-1){1'b0}}, usren_q};
            RID_IEN_SET, RID_IEN_CLR: rdata = inten_q;
            default:                  rdata = '0;
        endcase
    end

endmodule

// File: rtl/perfmon_regs.sv
module perfmon_regs
    import perfmon_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          ID_TOP_W   = 8,
    parameter int          EVT_W      = 8,
    parameter logic [31:0] CTRL_WMASK = 32'h0000_0039
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cpu_id,
    input  logic              feat_en,
    input  logic              req_valid,
    input  logic [3:0]        req_grp,
    input  logic [2:0]        req_sel,
    input  logic              req_wr,
    input  logic              req_user,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_undef
);

    reg_id_e           rid;
    logic              dec_undef;
    logic              acc_ok;
    logic              acc_we;
    logic [DATA_W-1:0] mux_data;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] cnten_q;
    logic [DATA_W-1:0] ovf_q;
    logic [EVT_W-1:0]  evt_q;
    logic              usren_q;
    logic [DATA_W-1:0] inten_q;

    perfmon_decode u_decode (
        .grp    (req_grp),
        .sel    (req_sel),
        .wr     (req_wr),
        .user   (req_user),
        .feat   (feat_en),
        .usr_en (usren_q),
        .rid    (rid),
        .undef  (dec_undef)
    );

    assign acc_ok = req_valid && !dec_undef;
    assign acc_we = acc_ok && req_wr;

    perfmon_state #(
        .DATA_W     (DATA_W),
        .ID_TOP_W   (ID_TOP_W),
        .EVT_W      (EVT_W),
        .CTRL_WMASK (CTRL_WMASK)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_id  (cpu_id),
        .we      (acc_we),
        .rid     (rid),
        .wdata   (req_wdata),
        .ctrl_q  (ctrl_q),
        .cnten_q (cnten_q),
        .ovf_q   (ovf_q),
        .evt_q   (evt_q),
        .usren_q (usren_q),
        .inten_q (inten_q)
    );

    perfmon_rdmux #(
        .DATA_W (DATA_W),
        .EVT_W  (EVT_W)
    ) u_rdmux (
        .rid     (rid),
        .ctrl_q  (ctrl_q),
        .cnten_q (cnten_q),
        .ovf_q   (ovf_q),
        .evt_q   (evt_q),
        .usren_q (usren_q),
        .inten_q (inten_q),
        .rdata   (mux_data)
    );

    assign rsp_rdata = (acc_ok && !req_wr) ? mux_data : '0;
    assign rsp_undef = req_valid && dec_undef;

endmodule

// File: rtl/perfmon_regs_chk.sv
module perfmon_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        feat_en,
    input logic        req_valid,
    input logic [3:0]  req_grp,
    input logic [2:0]  req_sel,
    input logic        req_wr,
    input logic        req_user,
    input logic [31:0] req_wdata,
    input logic [31:0] rsp_rdata,
    input logic        rsp_undef,
    input logic [31:0] ctrl_q,
    input logic [31:0] cnten_q,
    input logic [7:0]  evt_q,
    input logic        usren_q
);

    assert_feat_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !feat_en) |-> rsp_undef);

    assert_bad_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_grp == 4'd13 && req_sel > 3'd2) |-> rsp_undef);

    assert_user_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user && !usren_q && req_grp == 4'd12) |-> rsp_undef);

    assert_usren_wr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user && req_grp == 4'd14 && req_sel == 3'd0 && req_wr) |-> rsp_undef);

    assert_undef_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_undef) |-> (rsp_rdata == 32'd0));

    assert_undef_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_undef) |=> ($stable(ctrl_q) && $stable(cnten_q) && $stable(evt_q) && $stable(usren_q)));

    assert_ctrl_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(ctrl_q & ~32'h0000_0039));

    assert_cen_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_undef && req_wr && req_grp == 4'd12 && req_sel == 3'd1 && req_wdata[31])
        |=> cnten_q[31]);

    assert_evt_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_undef && req_wr && req_grp == 4'd13 && req_sel == 3'd1)
        |=> (evt_q == $past(req_wdata[7:0])));

    assert_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!rsp_undef && rsp_rdata == 32'd0));

endmodule

bind perfmon_regs perfmon_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .feat_en   (feat_en),
    .req_valid (req_valid),
    .req_grp   (req_grp),
    .req_sel   (req_sel),
    .req_wr    (req_wr),
    .req_user  (req_user),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .rsp_undef (rsp_undef),
    .ctrl_q    (ctrl_q),
    .cnten_q   (cnten_q),
    .evt_q     (evt_q),
    .usren_q   (usren_q)
);

// File: tb/test_perfmon_regs.sv
module test_perfmon_regs;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cpu_id;
    logic        feat_en;
    logic        req_valid;
    logic [3:0]  req_grp;
    logic [2:0]  req_sel;
    logic        req_wr;
    logic        req_user;
    logic [31:0] req_wdata;
    logic [31:0] rsp_rdata;
    logic        rsp_undef;

    always #2 clk = ~clk;

    perfmon_regs i_perfmon_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_id    (cpu_id),
        .feat_en   (feat_en),
        .req_valid (req_valid),
        .req_grp   (req_grp),
        .req_sel   (req_sel),
        .req_wr    (req_wr),
        .req_user  (req_user),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata),
        .rsp_undef (rsp_undef)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int n_acc  = 0;

    // bench-side register model
    logic [31:0] m_ctrl, m_cnten, m_ovf, m_inten;
    logic [7:0]  m_evt;
    logic        m_usren;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic bit is_defined(input logic [3:0] g, input logic [2:0] s);
        return (g == 4'd12 && s <= 3'd5) || (g == 4'd13 && s <= 3'd2) || (g == 4'd14 && s <= 3'd2);
    endfunction

    function automatic bit exp_undef(input logic f, input logic [3:0] g, input logic [2:0] s,
                                     input logic w, input logic u);
        if (!f || !is_defined(g, s)) return 1'b1;
        if (!u) return 1'b0;
        if (g == 4'd12 || g == 4'd13) return !m_usren;
        return !(s == 3'd0 && !w);
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] g, input logic [2:0] s);
        if (g == 4'd12) begin
            if (s == 3'd0) return m_ctrl;
            if (s == 3'd1 || s == 3'd2) return m_cnten;
            if (s == 3'd3) return m_ovf;
            return 32'd0;
        end
        if (g == 4'd13) return (s == 3'd1) ? {24'd0, m_evt} : 32'd0;
        if (s == 3'd0) return {31'd0, m_usren};
        return m_inten;
    endfunction

    function automatic string auto_tag(input logic f, input logic [3:0] g, input logic [2:0] s,
                                       input logic u);
        if (!f) return "R9";
        if (!is_defined(g, s)) return "R10";
        if (u && g == 4'd14) return "R12";
        if (u) return "R11";
        if (g == 4'd12) begin
            if (s == 3'd0) return "R2";
            if (s == 3'd3) return "R4";
            if (s >= 3'd4) return "R6";
            return "R3";
        end
        if (g == 4'd13) return (s == 3'd1) ? "R5" : "R6";
        return (s == 3'd0) ? "R7" : "R8";
    endfunction

    task automatic model_write(input logic [3:0] g, input logic [2:0] s, input logic [31:0] d);
        if (g == 4'd12) begin
            if (s == 3'd0) m_ctrl = (m_ctrl & ~32'h39) | (d & 32'h39);
            if (s == 3'd1) m_cnten = m_cnten | (d & 32'h8000_0000);
            if (s == 3'd2) m_cnten = m_cnten & ~(d & 32'h8000_0000);
            if (s == 3'd3) m_ovf = m_ovf & ~d;
        end else if (g == 4'd13) begin
            if (s == 3'd1) m_evt = d[7:0];
        end else if (g == 4'd14) begin
            if (s == 3'd0) m_usren = d[0];
            if (s == 3'd1) m_inten = m_inten | (d & 32'h8000_0000);
            if (s == 3'd2) m_inten = m_inten & ~(d & 32'h8000_0000);
        end
    endtask

    // one access: drive after the falling edge, sample before the rising edge
    task automatic access(input logic [3:0] g, input logic [2:0] s, input logic w,
                          input logic u, input logic [31:0] d, input string tag);
        logic        eu;
        logic [31:0] er;
        string       t;
        @(negedge clk);
        req_valid = 1'b1;
        req_grp   = g;
        req_sel   = s;
        req_wr    = w;
        req_user  = u;
        req_wdata = d;
        #1;
        t  = (tag == "") ? auto_tag(feat_en, g, s, u) : tag;
        eu = exp_undef(feat_en, g, s, w, u);
        er = (eu || w) ? 32'd0 : exp_read(g, s);
        chk({31'd0, rsp_undef}, {31'd0, eu}, {t, " undef"});
        chk(rsp_rdata, er, {t, " rdata"});
        @(posedge clk);
        if (!eu && w) model_write(g, s, d);
        n_acc++;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_wr    = 1'b0;
        req_user  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R14 watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        cpu_id    = 32'h41C2_5A7E;
        feat_en   = 1'b1;
        req_valid = 1'b0;
        req_grp   = 4'd0;
        req_sel   = 3'd0;
        req_wr    = 1'b0;
        req_user  = 1'b0;
        req_wdata = 32'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n   = 1'b1;
        m_ctrl  = cpu_id & 32'hFF00_0000;
        m_cnten = 32'd0;
        m_ovf   = 32'd0;
        m_evt   = 8'd0;
        m_usren = 1'b0;
        m_inten = 32'd0;

        // R1: reset values through privileged reads
        access(4'd12, 3'd0, 1'b0, 1'b0, 32'd0, "R1");
        chk(rsp_rdata, 32'h4100_0000, "R1 ctrl literal");
        access(4'd12, 3'd1, 1'b0, 1'b0, 32'd0, "R1");
        access(4'd12, 3'd3, 1'b0, 1'b0, 32'd0, "R1");
        access(4'd13, 3'd1, 1'b0, 1'b0, 32'd0, "R1");
        access(4'd14, 3'd0, 1'b0, 1'b0, 32'd0, "R1");
        access(4'd14, 3'd1, 1'b0, 1'b0, 32'd0, "R1");

        // R14: idle strobe gives zero outputs
        idle();
        #1;
        chk({31'd0, rsp_undef}, 32'd0, "R14 idle undef");
        chk(rsp_rdata, 32'd0, "R14 idle rdata");

        // R14/R5: write visible on the very next access
        access(4'd13, 3'd1, 1'b1, 1'b0, 32'h1234_56AB, "R5");
        access(4'd13, 3'd1, 1'b0, 1'b0, 32'd0, "R14");
        chk(rsp_rdata, 32'h0000_00AB, "R14 evt next cycle");

        // R2: all-ones then all-zeros control write
        access(4'd12, 3'd0, 1'b1, 1'b0, 32'hFFFF_FFFF, "R2");
        access(4'd12, 3'd0, 1'b0, 1'b0, 32'd0, "R2");
        chk(rsp_rdata, 32'h4100_0039, "R2 ctrl ones");

        // R3/R8: set then clear the cycle-counter enable bits
        access(4'd12, 3'd1, 1'b1, 1'b0, 32'hFFFF_FFFF, "R3");
        access(4'd12, 3'd2, 1'b0, 1'b0, 32'd0, "R3");
        chk(rsp_rdata, 32'h8000_0000, "R3 via clear sel");
        access(4'd14, 3'd1, 1'b1, 1'b0, 32'h8000_0001, "R8");
        access(4'd14, 3'd2, 1'b1, 1'b0, 32'h7FFF_FFFF, "R8");
        access(4'd14, 3'd2, 1'b0, 1'b0, 32'd0, "R8");
        chk(rsp_rdata, 32'h8000_0000, "R8 clear w/o bit31");

        // R13: refused user write leaves control unchanged
        access(4'd12, 3'd0, 1'b1, 1'b1, 32'h0000_0000, "R13");
        access(4'd12, 3'd0, 1'b0, 1'b0, 32'd0, "R13");
        chk(rsp_rdata, 32'h4100_0039, "R13 ctrl held");

        // sweep: every group/selector/direction/privilege, strap off and on,
        // user enable starting at 0 and 1
        for (int ue = 0; ue < 2; ue++) begin
            for (int f = 0; f < 2; f++) begin
                idle();
                feat_en = 1'b1;
                access(4'd14, 3'd0, 1'b1, 1'b0, ue[31:0], "R7");
                idle();
                feat_en = f[0];
                for (int g = 0; g < 16; g++) begin
                    for (int s = 0; s < 8; s++) begin
                        for (int w = 0; w < 2; w++) begin
                            for (int u = 0; u < 2; u++) begin
                                access(g[3:0], s[2:0], w[0], u[0],
                                       32'hA5C3_0F5A ^ (n_acc * 32'h9E37_79B9), "");
                            end
                        end
                    end
                end
            end
        end

        idle();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule